// File: doc/BRIEF.md
# Video Preamplifier Control Register Bank with Vertical-Blank Commit

This block is the control front end of a three-channel video preamplifier. It is a write-only I2C target. A host addresses it, gives a starting register index and then streams bytes into a staging bank. The analog side never sees those staged bytes directly. The whole bank is copied into the live registers in one clock cycle, and only when a vertical blanking pulse ends, so a picture is never drawn with half of a settings update. The host can therefore send at any time.

The vertical interval is taken from a composite blanking input that also carries short line pulses. The block measures each high pulse in system clock cycles. Only a pulse that lasts at least `VB_MIN_CYC` cycles is treated as vertical; at 50 MHz, 300 µs is 15000 cycles. The copy happens on the falling edge of a qualifying pulse. If an I2C transfer is open at that moment (a START has been seen and no STOP yet), the copy is skipped. Everything staged is then carried over to the next qualifying pulse.

The I2C engine is built from three state machines. It samples SCL and SDA through two-flop synchronizers and finds START and STOP from SDA edges while SCL is high. The bus engine has these states: IDLE, ADDR (shift the address byte), ADDR_ACK, SUB (shift the index byte), SUB_ACK, DATA, DATA_ACK and SKIP (addressed elsewhere).
- START always moves the engine to ADDR, and STOP always moves it to IDLE.
- After the eighth bit, ADDR goes to ADDR_ACK on a match and to SKIP otherwise. SUB goes to SUB_ACK, and DATA goes to DATA_ACK.
- Every ACK state leaves to SUB or DATA on the falling SCL edge that ends the ninth clock.

The pulse qualifier has three states: LOW, SHORT (high, still under threshold) and LONG (high, threshold reached). LOW moves to SHORT when blanking goes high. SHORT returns to LOW if blanking drops early, or moves to LONG when the threshold is reached. LONG returns to LOW when blanking drops, and that transition raises the commit strobe.

Top module: `vpr_ctrl_bank`

## Requirements
- R1: The block acknowledges only the address byte 0x40 (target address 0x20, write bit 0); any other address byte, including 0x41, gets no ACK. The rest of that transfer up to STOP changes no staged or live register.
- R2: Once the address matches, the block pulls SDA low (sda_oe = 1) during the ninth clock of the index byte and of every data byte.
- R3: The low four bits of the byte after the address set the register index; each data byte is staged at the current index, which then advances by one.
- R4: Bytes aimed at indices 0xB to 0xF are acknowledged and discarded; the index stops at 0xF and never wraps back to 0x0.
- R5: Staged bytes do not reach any output until a commit.
- R6: A blanking pulse high for at least VB_MIN_CYC system clocks commits on its falling edge; a shorter pulse commits nothing.
- R7: A commit updates all eleven live registers in the same cycle, each with the newest byte staged before the pulse ended.
- R8: If a transfer is open (START seen, no STOP) when a qualifying pulse ends, the outputs keep their values; the staged data is applied at the next qualifying pulse.
- R9: Field layout. Index 0 is contrast, 2/3/4 are red/green/blue cutoff, 6 is common cutoff, and 7/8/9 are red/green/blue sub-contrast (all 8 bits). Index 1 has blank mode in bit 7 and brightness in bits 5:0 (bit 6 is unused). Index 5 has slice level in bits 7:6 and OSD gain in bits 5:0. Index 0xA has detector-off in bit 7, sharpness-off in bit 6, sync-off in bit 5, time-constant select in bit 4 and sharpness gain in bits 3:0.
- R10: After reset every output is 0 and sda_oe is 0, and this holds until the first qualifying pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low (open-drain ACK) |
| blank_i | input | 1 | Composite blanking, active high |
| contrast | output | 8 | Common gain |
| blank_mode | output | 1 | Blanking level select |
| brightness | output | 6 | Common black level |
| cutoff_r | output | 8 | Red cutoff |
| cutoff_g | output | 8 | Green cutoff |
| cutoff_b | output | 8 | Blue cutoff |
| slice_lvl | output | 2 | Video detector slice level |
| osd_gain | output | 6 | On-screen display gain |
| cutoff_all | output | 8 | Common cutoff |
| subcon_r | output | 8 | Red sub-contrast |
| subcon_g | output | 8 | Green sub-contrast |
| subcon_b | output | 8 | Blue sub-contrast |
| det_off | output | 1 | Video detector output disable |
| shp_off | output | 1 | Sharpness disable |
| sync_off | output | 1 | Sync output disable |
| shp_tc | output | 1 | Sharpness time-constant select |
| shp_gain | output | 4 | Sharpness gain |

## Verification
A wrong bus state or a wrong bit count shows up within a byte, at the ninth clock, as a missing or misplaced ACK. A wrong index or a wrong field packing stays hidden until the next commit. It then appears as one output port holding another register's byte. A wrong pulse-width count or wrong commit gating appears at the falling edge of a blanking pulse. The outputs then change too early or after a short pulse, stay frozen after a long one, or take staged data while a transfer is still open. All of these are visible within a few clocks of that edge.

// File: rtl/vpr_pkg.sv
package vpr_pkg;

    localparam int NREG  = 11;
    localparam int PTR_W = 4;

    localparam int IX_CONTRAST = 0;
    localparam int IX_BRIGHT   = 1;
    localparam int IX_CUT_R    = 2;
    localparam int IX_CUT_G    = 3;
    localparam int IX_CUT_B    = 4;
    localparam int IX_OSD      = 5;
    localparam int IX_CUT_ALL  = 6;
    localparam int IX_SUB_R    = 7;
    localparam int IX_SUB_G    = 8;
    localparam int IX_SUB_B    = 9;
    localparam int IX_FLAGS    = 10;

    typedef enum logic [2:0] {
        I_IDLE,
        I_ADDR,
        I_ADDR_ACK,
        I_SUB,
        I_SUB_ACK,
        I_DATA,
        I_DATA_ACK,
        I_SKIP
    } i2c_st_t;

    typedef enum logic [1:0] {
        V_LOW,
        V_SHORT,
        V_LONG
    } vb_st_t;

endpackage

// File: rtl/vpr_i2c_wr.sv
module vpr_i2c_wr
    import vpr_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'h40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             xfer_busy
);

    // two synchronizer flops plus one history flop per line
    logic [2:0] scl_sh, sda_sh;
    logic       scl_s, scl_p, sda_s, sda_p;
    logic       scl_rise, scl_fall, start_c, stop_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= 3'b111;
            sda_sh <= 3'b111;
        end else begin
            scl_sh <= {scl_sh[1:0], scl_i};
            sda_sh <= {sda_sh[1:0], sda_i};
        end
    end

    assign scl_s    = scl_sh[1];
    assign scl_p    = scl_sh[2];
    assign sda_s    = sda_sh[1];
    assign sda_p    = sda_sh[2];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;

    i2c_st_t          st, st_n;
    logic [7:0]       shreg;
    logic [3:0]       bitcnt;
    logic [PTR_W-1:0] ptr;
    logic             busy_q;
    logic             wr_en_q;
    logic [PTR_W-1:0] wr_idx_q;
    logic [7:0]       wr_data_q;
    logic             byte_done;
    logic             shifting;
    logic             in_ack;

    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign shifting  = (st == I_ADDR) || (st == I_SUB) || (st == I_DATA);
    assign in_ack    = (st == I_ADDR_ACK) || (st == I_SUB_ACK) || (st == I_DATA_ACK);

    // next-state logic
    always_comb begin
        st_n = st;
        if (start_c) begin
            st_n = I_ADDR;
        end else if (stop_c) begin
            st_n = I_IDLE;
        end else begin
            unique case (st)
                I_IDLE: begin
                    st_n = I_IDLE;
                end
                I_SKIP: begin
                    st_n = I_SKIP;
                end
                I_ADDR: begin
                    if (byte_done) st_n = (shreg == DEV_ADDR) ? I_ADDR_ACK : I_SKIP;
                end
                I_ADDR_ACK: begin
                    if (scl_fall) st_n = I_SUB;
                end
                I_SUB: begin
                    if (byte_done) st_n = I_SUB_ACK;
                end
                I_SUB_ACK: begin
                    if (scl_fall) st_n = I_DATA;
                end
                I_DATA: begin
                    if (byte_done) st_n = I_DATA_ACK;
                end
                I_DATA_ACK: begin
                    if (scl_fall) st_n = I_DATA;
                end
                default: begin
                    st_n = I_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= I_IDLE;
        else        st <= st_n;
    end

    // shift register, bit counter, index pointer, write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bitcnt    <= '0;
            ptr       <= '0;
            busy_q    <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_idx_q  <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (start_c) begin
                bitcnt <= '0;
                busy_q <= 1'b1;
            end else if (stop_c) begin
                bitcnt <= '0;
                busy_q <= 1'b0;
            end else begin
                if (scl_rise && shifting && (bitcnt < 4'd8)) begin
                    shreg  <= {shreg[6:0], sda_s};
                    bitcnt <= bitcnt + 4'd1;
                end
                if (scl_fall && in_ack) begin
                    bitcnt <= '0;
                end
                if (byte_done && (st == I_SUB)) begin
                    ptr <= shreg[PTR_W-1:0];
                end
                if (byte_done && (st == I_DATA)) begin
                    wr_en_q   <= 1'b1;
                    wr_idx_q  <= ptr;
                    wr_data_q <= shreg;
                    if (ptr != '1) ptr <= ptr + PTR_W'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe    = in_ack;
        wr_en     = wr_en_q;
        wr_idx    = wr_idx_q;
        wr_data   = wr_data_q;
        xfer_busy = busy_q;
    end

    // R3: a byte produces exactly one staging strobe
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R4: the pointer advances after a write, or sits at the top index
    a_r4_ptr_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((ptr == wr_idx + PTR_W'(1)) || ((wr_idx == '1) && (ptr == '1))));

    // R2: the ACK drive is released on the falling SCL edge that ends the ninth clock
    a_r2_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && scl_fall && !start_c && !stop_c) |=> !sda_oe);

    // R1: a non-matching address never leads to an acknowledge
    a_r1_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == I_SKIP && !start_c) |=> !sda_oe);

endmodule

// File: rtl/vpr_vblank.sv
module vpr_vblank
    import vpr_pkg::*;
#(
    parameter int VB_MIN_CYC = 15000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blank_i,
    output logic commit
);

    localparam int CW = $clog2(VB_MIN_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(VB_MIN_CYC - 1);

    logic [1:0]    blk_sh;
    logic          blk_s;
    logic [CW-1:0] cnt;
    vb_st_t        st, st_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) blk_sh <= '0;
        else        blk_sh <= {blk_sh[0], blank_i};
    end
    assign blk_s = blk_sh[1];

    // next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            V_LOW:   if (blk_s) st_n = V_SHORT;
            V_SHORT: begin
                if (!blk_s)          st_n = V_LOW;
                else if (cnt >= LIM) st_n = V_LONG;
            end
            V_LONG:  if (!blk_s) st_n = V_LOW;
            default: st_n = V_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= V_LOW;
        else        st <= st_n;
    end

    // width counter: high samples seen so far, minus one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (st == V_LOW) begin
            cnt <= CW'(1);
        end else if (st == V_SHORT && blk_s && cnt < LIM) begin
            cnt <= cnt + CW'(1);
        end
    end

    // outputs
    always_comb begin
        commit = (st == V_LONG) && !blk_s;
    end

    // R6: a commit ends a long pulse and the qualifier returns to idle
    a_r6_commit_to_low: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (st == V_LOW));

    // R6: a short pulse ending never commits
    a_r6_short_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == V_SHORT) |-> !commit);

endmodule

// File: rtl/vpr_regbank.sv
module vpr_regbank
    import vpr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PTR_W-1:0]     wr_idx,
    input  logic [7:0]           wr_data,
    input  logic                 commit,
    input  logic                 busy,
    output logic [NREG-1:0][7:0] live_o
);

    logic [NREG-1:0][7:0] stage_w;
    logic                 take;

    assign take = commit && !busy;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [7:0] stg_q;
        logic [7:0] live_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q <= '0;
            end else if (wr_en && (wr_idx == PTR_W'(i))) begin
                stg_q <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_q <= '0;
            end else if (take) begin
                live_q <= stg_q;
            end
        end

        assign stage_w[i] = stg_q;
        assign live_o[i]  = live_q;
    end

    // R7: an accepted commit copies the whole staging bank in one cycle
    a_r7_bank_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !busy) |=> (live_o == $past(stage_w)));

    // R8: an open transfer freezes the live bank
    a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(live_o));

    // R5: without a commit the live bank does not move
    a_r5_no_leak: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(live_o));

endmodule

// File: rtl/vpr_ctrl_bank.sv
module vpr_ctrl_bank
    import vpr_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR   = 8'h40,
    parameter int         VB_MIN_CYC = 15000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       blank_i,
    output logic [7:0] contrast,
    output logic       blank_mode,
    output logic [5:0] brightness,
    output logic [7:0] cutoff_r,
    output logic [7:0] cutoff_g,
    output logic [7:0] cutoff_b,
    output logic [1:0] slice_lvl,
    output logic [5:0] osd_gain,
    output logic [7:0] cutoff_all,
    output logic [7:0] subcon_r,
    output logic [7:0] subcon_g,
    output logic [7:0] subcon_b,
    output logic       det_off,
    output logic       shp_off,
    output logic       sync_off,
    output logic       shp_tc,
    output logic [3:0] shp_gain
);

    logic                 wr_en;
    logic [PTR_W-1:0]     wr_idx;
    logic [7:0]           wr_data;
    logic                 busy;
    logic                 commit;
    logic [NREG-1:0][7:0] live;
    logic                 unused_bit6;

    vpr_i2c_wr #(.DEV_ADDR(DEV_ADDR)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .xfer_busy (busy)
    );

    vpr_vblank #(.VB_MIN_CYC(VB_MIN_CYC)) u_vb (
        .clk     (clk),
        .rst_n   (rst_n),
        .blank_i (blank_i),
        .commit  (commit)
    );

    vpr_regbank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .commit  (commit),
        .busy    (busy),
        .live_o  (live)
    );

    assign contrast    = live[IX_CONTRAST];
    assign blank_mode  = live[IX_BRIGHT][7];
    assign unused_bit6 = live[IX_BRIGHT][6];
    assign brightness  = live[IX_BRIGHT][5:0];
    assign cutoff_r    = live[IX_CUT_R];
    assign cutoff_g    = live[IX_CUT_G];
    assign cutoff_b    = live[IX_CUT_B];
    assign slice_lvl   = live[IX_OSD][7:6];
    assign osd_gain    = live[IX_OSD][5:0];
    assign cutoff_all  = live[IX_CUT_ALL];
    assign subcon_r    = live[IX_SUB_R];
    assign subcon_g    = live[IX_SUB_G];
    assign subcon_b    = live[IX_SUB_B];
    assign det_off     = live[IX_FLAGS][7];
    assign shp_off     = live[IX_FLAGS][6];
    assign sync_off    = live[IX_FLAGS][5];
    assign shp_tc      = live[IX_FLAGS][4];
    assign shp_gain    = live[IX_FLAGS][3:0];

endmodule

// File: tb/vpr_ctrl_bank_test.sv
module vpr_ctrl_bank_test;

    localparam int VB = 200;
    localparam int Q  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_tb = 1'b1;
    logic sda_tb = 1'b1;
    logic blank_i = 1'b0;
    logic sda_line;
    logic sda_oe;
    logic [7:0] contrast, cutoff_r, cutoff_g, cutoff_b, cutoff_all;
    logic [7:0] subcon_r, subcon_g, subcon_b;
    logic       blank_mode, det_off, shp_off, sync_off, shp_tc;
    logic [5:0] brightness, osd_gain;
    logic [1:0] slice_lvl;
    logic [3:0] shp_gain;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic [7:0] exp_live [11];
    logic [7:0] exp_stage [11];
    logic [7:0] payload [8];

    always #10 clk = ~clk;
    assign sda_line = sda_tb & ~sda_oe;

    vpr_ctrl_bank #(.VB_MIN_CYC(VB)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_tb), .sda_i(sda_line), .sda_oe(sda_oe),
        .blank_i(blank_i), .contrast(contrast), .blank_mode(blank_mode),
        .brightness(brightness), .cutoff_r(cutoff_r), .cutoff_g(cutoff_g),
        .cutoff_b(cutoff_b), .slice_lvl(slice_lvl), .osd_gain(osd_gain),
        .cutoff_all(cutoff_all), .subcon_r(subcon_r), .subcon_g(subcon_g),
        .subcon_b(subcon_b), .det_off(det_off), .shp_off(shp_off),
        .sync_off(sync_off), .shp_tc(shp_tc), .shp_gain(shp_gain)
    );

    // {index, byte} pairs; each is written, committed and compared
    localparam logic [11:0] VEC [8] = '{
        {4'h0, 8'hA5}, {4'h1, 8'hFF}, {4'h2, 8'h3C}, {4'h5, 8'h9E},
        {4'h6, 8'h81}, {4'h8, 8'h5A}, {4'h9, 8'hE7}, {4'hA, 8'h6B}
    };

    function automatic logic [7:0] port_val(input int ix);
        case (ix)
            0:  return contrast;
            1:  return {blank_mode, 1'b0, brightness};
            2:  return cutoff_r;
            3:  return cutoff_g;
            4:  return cutoff_b;
            5:  return {slice_lvl, osd_gain};
            6:  return cutoff_all;
            7:  return subcon_r;
            8:  return subcon_g;
            9:  return subcon_b;
            default: return {det_off, shp_off, sync_off, shp_tc, shp_gain};
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 11; i++) begin
            logic [7:0] m;
            m = (i == 1) ? 8'hBF : 8'hFF;
            chk(req, {24'd0, port_val(i)}, {24'd0, exp_live[i] & m});
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_tb = 1'b1; scl_tb = 1'b1; wq(Q);
        sda_tb = 1'b0; wq(Q);
        scl_tb = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_tb = 1'b0; wq(Q);
        scl_tb = 1'b1; wq(Q);
        sda_tb = 1'b1; wq(Q);
    endtask

    task automatic bus_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_tb = b[i]; wq(Q);
            scl_tb = 1'b1; wq(2 * Q);
            scl_tb = 1'b0; wq(Q);
        end
        sda_tb = 1'b1; wq(Q);
        scl_tb = 1'b1; wq(Q);
        ack = ~sda_line;
        wq(Q);
        scl_tb = 1'b0; wq(Q);
    endtask

    // address, index, n payload bytes; optional STOP; ACKs checked
    task automatic xfer(input logic [7:0] dev, input logic [3:0] ix, input int n,
                        input bit stop, input string req);
        logic a;
        logic want;
        logic [3:0] p;
        want = (dev == 8'h40);
        bus_start();
        bus_byte(dev, a);
        chk({req, " address ack R1"}, {31'd0, a}, {31'd0, want});
        bus_byte({4'h0, ix}, a);
        chk({req, " index ack R2"}, {31'd0, a}, {31'd0, want});
        p = ix;
        for (int k = 0; k < n; k++) begin
            bus_byte(payload[k], a);
            chk({req, " data ack R2"}, {31'd0, a}, {31'd0, want});
            if (want) begin
                if (p <= 4'hA) exp_stage[p] = payload[k];
                if (p != 4'hF) p = p + 4'd1;
            end
        end
        if (stop) bus_stop();
    endtask

    task automatic vpulse(input int w, input bit qualifies);
        blank_i = 1'b1; wq(w);
        blank_i = 1'b0; wq(10);
        if (qualifies) exp_live = exp_stage;
    endtask

    initial begin
        for (int i = 0; i < 11; i++) begin
            exp_live[i] = 8'h00;
            exp_stage[i] = 8'h00;
        end
        wq(5);
        // R10: reset state
        chk("R10 sda_oe at reset", {31'd0, sda_oe}, 32'd0);
        check_all("R10 outputs at reset");
        rst_n = 1'b1;
        wq(5);
        vpulse(VB + 50, 1'b1);
        check_all("R10 zero after first commit");

        // vector table: R3 staging per index, R6 commit, R9 field layout
        for (int v = 0; v < 8; v++) begin
            payload[0] = VEC[v][7:0];
            xfer(8'h40, VEC[v][11:8], 1, 1'b1, "R3 vector");
            vpulse(VB + 50, 1'b1);
            check_all("R9 vector commit");
        end

        // R9: explicit flag fields from index 0xA = 0x6B
        chk("R9 det_off", {31'd0, det_off}, 32'd0);
        chk("R9 shp_off", {31'd0, shp_off}, 32'd1);
        chk("R9 sync_off", {31'd0, sync_off}, 32'd1);
        chk("R9 shp_tc", {31'd0, shp_tc}, 32'd0);
        chk("R9 shp_gain", {28'd0, shp_gain}, 32'hB);

        // R5: staged but not committed
        payload[0] = 8'h33;
        xfer(8'h40, 4'h3, 1, 1'b1, "R5 stage");
        wq(50);
        check_all("R5 no commit yet");
        // R6: short pulse ignored
        vpulse(VB - 50, 1'b0);
        check_all("R6 short pulse");
        vpulse(VB + 50, 1'b1);
        check_all("R6 long pulse");

        // R3/R7: burst with auto-increment, then a rewrite: newest wins
        payload[0] = 8'h71; payload[1] = 8'h82; payload[2] = 8'h93;
        xfer(8'h40, 4'h7, 3, 1'b1, "R3 burst");
        payload[0] = 8'h11;
        xfer(8'h40, 4'h0, 1, 1'b1, "R7 first");
        payload[0] = 8'h22;
        xfer(8'h40, 4'h0, 1, 1'b1, "R7 second");
        vpulse(VB + 50, 1'b1);
        check_all("R7 burst and newest");
        chk("R7 newest contrast", {24'd0, contrast}, 32'h22);

        // R4: from 0xA, seven bytes; no wrap to index 0
        for (int k = 0; k < 7; k++) payload[k] = 8'hC0 + 8'(k);
        xfer(8'h40, 4'hA, 7, 1'b1, "R4 overflow");
        vpulse(VB + 50, 1'b1);
        check_all("R4 overflow discarded");
        chk("R4 index 0 untouched", {24'd0, contrast}, 32'h22);

        // R1: foreign address and read address ignored
        payload[0] = 8'h55;
        xfer(8'h42, 4'h2, 1, 1'b1, "R1 foreign");
        xfer(8'h41, 4'h2, 1, 1'b1, "R1 read");
        vpulse(VB + 50, 1'b1);
        check_all("R1 no effect");

        // R8: open transfer at pulse end defers the commit
        payload[0] = 8'h77;
        xfer(8'h40, 4'h3, 1, 1'b0, "R8 open");
        vpulse(VB + 50, 1'b0);
        check_all("R8 held while open");
        bus_stop();
        vpulse(VB + 50, 1'b1);
        check_all("R8 applied next pulse");
        chk("R8 cutoff_g", {24'd0, cutoff_g}, 32'h77);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule